// File: doc/BRIEF.md
# Memory Pattern Test Sequencer

This block is a self-test controller for a synchronous single-port RAM. It has separate address, write-data, read-data, write-enable and read-enable ports. A one-cycle start pulse makes it sweep the whole array four times, each time with a different data background. In each sweep every location is written first. Then every location is read back and compared with the word the controller regenerates for that address. It issues one access per clock and never leaves an idle cycle between sweeps.

The four backgrounds run in a fixed order: all-zeros, all-ones, the alternating 0x55 word, and a pseudo-random stream. The random stream comes from a 16-bit LFSR. The LFSR is returned to its seed when the read sweep begins, so the expected words equal the words that were written, and no copy of the written data is kept. At the end the block raises a one-cycle completion pulse. It also reports a sticky fail flag together with the first failing address, the expected word and the observed word.

Top module: `mbist_seq`

## Requirements
- R1: After an accepted start, the block issues exactly 8*N accesses (N = 2^(ROW_BITS+COL_BITS)), one per clock with no gaps. Sweep p (p = 0..3) writes all N locations and then reads all N locations. The backgrounds in sweep order are 0x00, 0xFF, 0x55 and random.
- R2: Within each write or read sweep, the address is {row, col} with the column in the low COL_BITS bits. The column steps fastest, so addresses run 0, 1, ..., N-1.
- R3: Each background acts on every bit of the word at once. The zero sweep writes all bits 0 and the ones sweep writes all bits 1. The alternating sweep sets bit i to 1 when i is even, which gives 0x55 for an 8-bit word.
- R4: The random word for the k-th location of a sweep is built from LFSR state s_k, where s_0 = 0xACE1 and s_{k+1} = {s_k[14:0], s_k[15]^s_k[13]^s_k[12]^s_k[10]}. Bit i of the word is s_k[i mod 16]. The read sweep expects the same words as the write sweep.
- R5: Read data is taken one clock after the read is issued, which matches a RAM with one cycle of read latency.
- R6: The first mismatch sets fail and captures the address, the expected word and the observed word. Later mismatches leave all four unchanged.
- R7: done is high for exactly one cycle, 8*N+1 rising edges after the edge that samples start. When done is high, fail and the captured values already include the last comparison, and the RAM is not being accessed.
- R8: A start pulse that arrives while a sequence is running has no effect on the access stream or on the completion timing.
- R9: A start accepted from idle clears fail and the captured address and data before the new run.
- R10: A synchronous active-high reset returns the block to idle. It drives write and read enables, done and fail low, and clears the captured values to zero.
- R11: The write enable and the read enable are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| mem_addr | output | ROW_BITS+COL_BITS | RAM address, {row, col} |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after mem_re |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ROW_BITS+COL_BITS | Address of the first mismatch |
| fail_exp | output | DATA_W | Expected word at the first mismatch |
| fail_obs | output | DATA_W | Observed word at the first mismatch |

## Verification
The assertions assume that reset is high from time zero for at least one edge, because the reset property and the address-step property both compare against the state held at that first edge. They also assume that start is a plain level sampled on the clock, so the sticky-flag and capture-stability properties can exclude only the cycles in which start is high. The bench meets both conditions: it holds reset for several cycles before the first stimulus, and it changes start only on falling edges. Its RAM model returns data one edge after a read. The faults it injects only change the returned word or add an extra write target, so no request to the RAM is ever missing a response.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    localparam int             LFSR_W    = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef enum logic [1:0] {
        BG_ZERO = 2'd0,
        BG_ONES = 2'd1,
        BG_ALT  = 2'd2,
        BG_RAND = 2'd3
    } bg_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } st_e;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic bg_bit(input bg_e bg, input logic alt_val,
                                    input logic rnd_val);
        logic b;
        case (bg)
            BG_ZERO: b = 1'b0;
            BG_ONES: b = 1'b1;
            BG_ALT:  b = alt_val;
            default: b = rnd_val;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         step,
    output logic [ROW_BITS+COL_BITS-1:0] addr,
    output logic                         last
);
    localparam logic [ROW_BITS-1:0] ROW_MAX = {ROW_BITS{1'b1}};
    localparam logic [COL_BITS-1:0] COL_MAX = {COL_BITS{1'b1}};

    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;
    logic                col_wrap;

    assign col_wrap = (col_q == COL_MAX);
    assign last     = col_wrap && (row_q == ROW_MAX);
    assign addr     = {row_q, col_q};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            row_q <= '0;
            col_q <= '0;
        end else if (step) begin
            if (col_wrap) begin
                col_q <= '0;
                row_q <= row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mbist_pattern_gen.sv
module mbist_pattern_gen
    import mbist_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reseed,
    input  logic              step,
    input  bg_e               bg,
    output logic [DATA_W-1:0] word
);
    logic [LFSR_W-1:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (rst || reseed) begin
            lfsr_q <= LFSR_SEED;
        end else if (step) begin
            lfsr_q <= lfsr_next(lfsr_q);
        end
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam int   LB  = i % LFSR_W;
        localparam logic ALT = ((i % 2) == 0);
        assign word[i] = bg_bit(bg, ALT, lfsr_q[LB]);
    end
endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
    import mbist_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cmp_busy,
    input  logic last,
    output logic start_ok,
    output logic wr,
    output logic rd,
    output logic phase_end,
    output logic final_rd,
    output bg_e  bg
);
    st_e st_q;
    bg_e bg_q;

    assign bg        = bg_q;
    assign start_ok  = start && (st_q == ST_IDLE) && !cmp_busy;
    assign wr        = (st_q == ST_WRITE);
    assign rd        = (st_q == ST_READ);
    assign phase_end = (wr || rd) && last;
    assign final_rd  = rd && last && (bg_q == BG_RAND);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            bg_q <= BG_ZERO;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        st_q <= ST_WRITE;
                        bg_q <= BG_ZERO;
                    end
                end
                ST_WRITE: begin
                    if (last) st_q <= ST_READ;
                end
                ST_READ: begin
                    if (last) begin
                        if (bg_q == BG_RAND) begin
                            st_q <= ST_IDLE;
                        end else begin
                            st_q <= ST_WRITE;
                            bg_q <= bg_e'(bg_q + 2'd1);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mbist_compare.sv
module mbist_compare #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          issue,
    input  logic          issue_last,
    input  logic [AW-1:0] issue_addr,
    input  logic [DW-1:0] issue_exp,
    input  logic [DW-1:0] rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_exp,
    output logic [DW-1:0] fail_obs
);
    logic          vld_q;
    logic          last_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] exp_q;
    logic          mismatch;

    assign busy     = vld_q;
    assign mismatch = vld_q && (rdata != exp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            last_q <= 1'b0;
            addr_q <= '0;
            exp_q  <= '0;
            done   <= 1'b0;
        end else begin
            vld_q  <= issue;
            last_q <= issue && issue_last;
            addr_q <= issue_addr;
            exp_q  <= issue_exp;
            done   <= vld_q && last_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_obs  <= '0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= addr_q;
            fail_exp  <= exp_q;
            fail_obs  <= rdata;
        end
    end
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4,
    parameter int DATA_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    output logic [ROW_BITS+COL_BITS-1:0] mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    output logic                         mem_we,
    output logic                         mem_re,
    input  logic [DATA_W-1:0]            mem_rdata,
    output logic                         done,
    output logic                         fail,
    output logic [ROW_BITS+COL_BITS-1:0] fail_addr,
    output logic [DATA_W-1:0]            fail_exp,
    output logic [DATA_W-1:0]            fail_obs
);
    localparam int AW = ROW_BITS + COL_BITS;

    logic          start_ok;
    logic          wr;
    logic          rd;
    logic          phase_end;
    logic          final_rd;
    logic          last;
    logic          cmp_busy;
    bg_e           bg;
    logic [DATA_W-1:0] word;
    logic [AW-1:0]     addr;

    mbist_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmp_busy  (cmp_busy),
        .last      (last),
        .start_ok  (start_ok),
        .wr        (wr),
        .rd        (rd),
        .phase_end (phase_end),
        .final_rd  (final_rd),
        .bg        (bg)
    );

    mbist_addr_gen #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS)
    ) u_addr (
        .clk   (clk),
        .rst   (rst),
        .clear (start_ok),
        .step  (wr || rd),
        .addr  (addr),
        .last  (last)
    );

    mbist_pattern_gen #(
        .DATA_W (DATA_W)
    ) u_pat (
        .clk    (clk),
        .rst    (rst),
        .reseed (start_ok || phase_end),
        .step   (wr || rd),
        .bg     (bg),
        .word   (word)
    );

    mbist_compare #(
        .AW (AW),
        .DW (DATA_W)
    ) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .clear      (start_ok),
        .issue      (rd),
        .issue_last (final_rd),
        .issue_addr (addr),
        .issue_exp  (word),
        .rdata      (mem_rdata),
        .busy       (cmp_busy),
        .done       (done),
        .fail       (fail),
        .fail_addr  (fail_addr),
        .fail_exp   (fail_exp),
        .fail_obs   (fail_obs)
    );

    assign mem_addr  = addr;
    assign mem_wdata = word;
    assign mem_we    = wr;
    assign mem_re    = rd;
endmodule

// File: rtl/mbist_seq_checker.sv
module mbist_seq_checker #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_re,
    input logic          done,
    input logic          fail,
    input logic [AW-1:0] fail_addr,
    input logic [DW-1:0] fail_exp,
    input logic [DW-1:0] fail_obs
);
    // R11
    p_we_re_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R7
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_we && !mem_re));

    // R6
    p_fail_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);

    p_capture_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> ($stable(fail_addr) && $stable(fail_exp) && $stable(fail_obs)));

    // R2
    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        ((mem_we || mem_re) && ($past(mem_we) || $past(mem_re)) && (mem_addr != '0))
        |-> ((mem_addr - $past(mem_addr)) == AW'(1)));

    // R10
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!mem_we && !mem_re && !done && !fail && (fail_addr == '0)
                 && (fail_exp == '0) && (fail_obs == '0)));
endmodule

bind mbist_seq mbist_seq_checker #(
    .AW (ROW_BITS + COL_BITS),
    .DW (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_exp  (fail_exp),
    .fail_obs  (fail_obs)
);

// File: tb/mbist_seq_bench.sv
module mbist_seq_bench;
    localparam int RB = 2;
    localparam int CB = 3;
    localparam int DW = 8;
    localparam int AW = RB + CB;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic          mem_re;
    logic [DW-1:0] mem_rdata;
    logic          done;
    logic          fail;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_exp;
    logic [DW-1:0] fail_obs;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    mbist_seq #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW)) u_mbist_seq (
        .clk (clk), .rst (rst), .start (start),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_we (mem_we),
        .mem_re (mem_re), .mem_rdata (mem_rdata), .done (done), .fail (fail),
        .fail_addr (fail_addr), .fail_exp (fail_exp), .fail_obs (fail_obs)
    );

    // RAM model with injectable faults
    logic [DW-1:0] mem [N];
    logic [DW-1:0] raw_q;
    logic [AW-1:0] raddr_q;
    bit            sa0_en = 0, sa1_en = 0, alias_en = 0;
    logic [AW-1:0] sa0_addr = '0, sa1_addr = '0;
    int            sa0_bit = 0, sa1_bit = 0;
    localparam logic [AW-1:0] ALIAS_SRC = 5'd17;
    localparam logic [AW-1:0] ALIAS_DST = 5'd3;

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            if (alias_en && mem_addr == ALIAS_SRC) mem[ALIAS_DST] <= mem_wdata;
        end
        if (mem_re) begin
            raw_q   <= mem[mem_addr];
            raddr_q <= mem_addr;
        end
    end

    always_comb begin
        mem_rdata = raw_q;
        if (sa1_en && raddr_q == sa1_addr) mem_rdata[sa1_bit] = 1'b1;
        if (sa0_en && raddr_q == sa0_addr) mem_rdata[sa0_bit] = 1'b0;
    end

    function automatic logic [DW-1:0] rand_word(input int k);
        logic [15:0] s = 16'hACE1;
        logic [DW-1:0] w;
        for (int j = 0; j < k; j++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
        for (int i = 0; i < DW; i++) w[i] = s[i % 16];
        return w;
    endfunction

    function automatic logic [DW-1:0] bg_word(input int p, input int k);
        logic [DW-1:0] w;
        case (p)
            0: w = '0;
            1: w = '1;
            2: for (int i = 0; i < DW; i++) w[i] = ((i % 2) == 0);
            default: w = rand_word(k);
        endcase
        return w;
    endfunction

    // access stream monitor
    int acc = 0;
    int acc_base = 0;
    int e_order = 0, e_addr = 0, e_fixed = 0, e_rand = 0, e_excl = 0;

    always @(negedge clk) begin
        if (!rst && (mem_we || mem_re)) begin
            int a, p, o, k;
            a = acc - acc_base;
            p = a / (2 * N);
            o = a % (2 * N);
            k = (o < N) ? o : o - N;
            if (mem_we && mem_re) e_excl++;
            if (p > 3 || (o < N) != mem_we) e_order++;
            if (int'(mem_addr) != k) e_addr++;
            if (mem_we && p <= 3 && mem_wdata != bg_word(p, k)) begin
                if (p == 3) e_rand++; else e_fixed++;
            end
            acc++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_seq(input bit exp_fail, input logic [AW-1:0] e_a,
                           input logic [DW-1:0] e_x, input logic [DW-1:0] e_o,
                           input bit mid_start);
        int n, eo, ea, ef, er, ex, a0;
        eo = e_order; ea = e_addr; ef = e_fixed; er = e_rand; ex = e_excl;
        acc_base = acc;
        a0 = acc;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 1;
        check(!fail, "R9", "fail cleared at start", fail, 0);
        while (!done && n < 8 * N + 20) begin
            @(negedge clk);
            n++;
            start = (mid_start && n == 40);
        end
        start = 1'b0;
        check(n == 8 * N + 2, mid_start ? "R8" : "R7", "done edge count", n - 1, 8 * N + 1);
        check(acc - a0 == 8 * N, "R1", "access count", acc - a0, 8 * N);
        check(e_order == eo && e_excl == ex, "R1", "sweep order", e_order - eo, 0);
        check(e_addr == ea, "R2", "address sequence", e_addr - ea, 0);
        check(e_fixed == ef, "R3", "fixed background words", e_fixed - ef, 0);
        check(e_rand == er, "R4", "random background words", e_rand - er, 0);
        check(fail == exp_fail, "R6", "fail flag", fail, exp_fail);
        check(fail_addr == e_a, "R6", "captured address", fail_addr, e_a);
        check(fail_exp == e_x, "R5", "captured expected", fail_exp, e_x);
        check(fail_obs == e_o, "R5", "captured observed", fail_obs, e_o);
        @(negedge clk);
        check(!done, "R7", "done one cycle", done, 0);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!mem_we && !mem_re && !done && !fail && fail_addr == 0 && fail_obs == 0,
              "R10", "reset state", {mem_we, mem_re, done, fail}, 0);
        rst = 1'b0;
        @(negedge clk);

        // clean run
        run_seq(0, '0, '0, '0, 0);
        // stuck-at-0 bit0 at address 5: first seen in the ones sweep
        sa0_en = 1; sa0_addr = 5'd5; sa0_bit = 0;
        run_seq(1, 5'd5, 8'hFF, 8'hFE, 0);
        sa0_en = 0;
        // clean run after a failing one (R9)
        run_seq(0, '0, '0, '0, 0);
        // two faults: stuck-at-1 wins in the zero sweep, later one not captured
        sa1_en = 1; sa1_addr = 5'd9; sa1_bit = 3;
        sa0_en = 1; sa0_addr = 5'd2; sa0_bit = 6;
        run_seq(1, 5'd9, 8'h00, 8'h08, 0);
        sa1_en = 0; sa0_en = 0;
        // alias fault only the random sweep reveals
        alias_en = 1;
        run_seq(1, ALIAS_DST, rand_word(3), rand_word(17), 0);
        alias_en = 0;
        // start while running is ignored (R8)
        run_seq(0, '0, '0, '0, 1);

        // reset in the middle of a failing run (R10)
        sa1_en = 1; sa1_addr = 5'd20; sa1_bit = 7;
        acc_base = acc;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (70) @(negedge clk);
        check(fail && fail_addr == 5'd20 && fail_obs == 8'h80, "R6",
              "fail before reset", fail_obs, 8'h80);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!fail && fail_addr == 0 && fail_exp == 0 && fail_obs == 0, "R10",
              "reset clears capture", {fail, fail_addr}, 0);
        begin
            int busy = 0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (mem_we || mem_re || done) busy++;
            end
            check(busy == 0, "R10", "idle after reset", busy, 0);
        end
        sa1_en = 0;
        run_seq(0, '0, '0, '0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule